// File: doc/BRIEF.md
# Power-On and Warm Reset Sequencer

This block turns a raw active-low reset pin and a few supply and status flags into the reset controls used inside a small programmable system device. It tells a first reset after power-up apart from a reset that arrives while the device is already running. The first kind is accepted only after a long low pulse. The second kind needs only a short one, and any pulse shorter than that is ignored. Once the pin returns high, the block holds the device in reset for a fixed number of extra cycles. The ready flag rises only after that hold.

While a reset is in effect, the block drives clear enables for three classes of register. The power-management pair and the macrocell flip-flops are cleared only on power-on. The general registers are cleared on both kinds. The block also loads the memory-map register with a configured default in which two mode bits are forced to zero. It forces the MCU port to input and floats the address and peripheral pins. A power-down request floats the peripheral and address pins but leaves the MCU port alone. When a reset is accepted while the flash reports busy, one abort strobe is issued. Flash writes stay inhibited while the supply is under the lockout level and throughout any reset.

The pin passes through a two-flop synchroniser. All widths are counted in clock cycles. A low level on the supply-good flag acts as the synchronous reset of the block, and it re-arms power-on detection.

Top module: `reset_sequencer`

## Requirements
- R1: While `supply_ok` is low, one clock edge brings the outputs to this state: `ready`=0, `mcu_in_force`=1, `addr_tri`=1, `periph_tri`=1, `wr_inhibit`=1, every clear and load output 0, and `flash_abort`=0.
- R2: After the supply comes up, a reset is accepted only if the pin is sampled low on at least POR_MIN_CYC consecutive edges. A shorter pulse, even one at or above WARM_MIN_CYC, leaves `ready` low and asserts no clear.
- R3: Once the device is running, a low pulse of at least WARM_MIN_CYC edges is accepted as a warm reset. A shorter pulse changes no output: `ready` stays 1 and no clear or port force is asserted.
- R4: Count as edge 0 the first edge at which the pin is sampled high after an accepted reset. `ready` rises right after edge HOLD_CYC+3, and it is low right after edge HOLD_CYC+2.
- R5: Take a pulse of L sampled-low edges accepted against a minimum M. Then `clr_gen` is high for exactly L-M+1+HOLD_CYC cycles. `clr_pm` and `clr_mcell` follow the same window on a power-on reset and stay 0 on a warm reset.
- R6: `map_load` is high during the same window as `clr_gen`. `map_init` equals MAP_DEFAULT with bits CODE_BIT and PERIPH_BIT cleared.
- R7: During a reset window, `mcu_in_force`, `addr_tri` and `periph_tri` are 1. When `ready` is 1, `mcu_in_force` is 0.
- R8: While running, a power-down request raises `periph_tri` and `addr_tri` one edge later. It leaves `mcu_in_force` at 0, asserts no clear and keeps `ready` at 1.
- R9: `flash_abort` is a one-cycle pulse, given once per accepted reset, and only when `flash_busy` is 1 at the edge where the reset is accepted. An ignored pulse gives no strobe.
- R10: `wr_inhibit` is 1 one edge after `wr_lockout` is 1 and throughout any reset. While running with `wr_lockout` low, it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| supply_ok | input | 1 | Supply steady; low acts as synchronous reset and re-arms power-on detection |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin |
| wr_lockout | input | 1 | Supply below the write-lockout level |
| pd_req | input | 1 | Power-down request |
| flash_busy | input | 1 | Flash program or erase in progress |
| ready | output | 1 | Device operational, memory access allowed |
| clr_pm | output | 1 | Clear power-management registers (power-on only) |
| clr_gen | output | 1 | Clear general registers (any reset) |
| clr_mcell | output | 1 | Clear macrocell flip-flops (power-on only) |
| map_load | output | 1 | Load memory-map register with `map_init` |
| map_init | output | MAP_W | Memory-map reset value |
| mcu_in_force | output | 1 | Force MCU port to input mode |
| addr_tri | output | 1 | Float address-out pins |
| periph_tri | output | 1 | Float peripheral I/O pins |
| flash_abort | output | 1 | One-cycle strobe ending a flash program or erase |
| wr_inhibit | output | 1 | Block flash write cycles |

## Verification
Two functions can land in the same cycle. The first case is a warm reset accepted while a power-down request is held, and flash is busy at the same time. The table vectors set `pd_req` and `flash_busy` across a whole pulse, so the accept edge, the abort strobe and the power-down port floating all overlap. The bench then judges by counting cycles. The MCU input force must cover exactly the reset window even though power-down never asserts it. The abort must occur once, and the peripheral pins must stay floated after `ready` returns.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,  // supply up, not yet reset-qualified
    ST_LOW  = 2'd1,  // pin low, width being measured
    ST_HOLD = 2'd2,  // post-release hold
    ST_RUN  = 2'd3   // operational
  } seq_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic clr,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (clr) pipe <= {STAGES{RST_VAL}};
    else     pipe <= {pipe[STAGES-2:0], d_async};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int unsigned POR_MIN_CYC  = 1000,
  parameter int unsigned WARM_MIN_CYC = 16,
  parameter int unsigned HOLD_CYC     = 256,
  localparam int unsigned CNT_W = $clog2(max_u(POR_MIN_CYC, HOLD_CYC) + 1)
) (
  input  logic clk,
  input  logic clr,
  input  logic pin_lvl,     // synchronised pin, 1 = released
  output logic in_reset,    // device not operational
  output logic rst_active,  // accepted reset window (clears apply)
  output logic is_por,      // current reset kind is power-on
  output logic accept       // cycle in which a reset becomes accepted
);
  localparam logic [CNT_W-1:0] POR_M     = CNT_W'(POR_MIN_CYC);
  localparam logic [CNT_W-1:0] WARM_M    = CNT_W'(WARM_MIN_CYC);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             por_flag;
  logic             relock;   // pin fell again during hold
  logic [CNT_W-1:0] min_cur;
  logic             pin_low;
  logic             qual;

  assign pin_low = ~pin_lvl;
  assign min_cur = por_flag ? POR_M : WARM_M;
  assign qual    = (state == ST_LOW) && (cnt >= min_cur);

  always_ff @(posedge clk) begin
    if (clr) begin
      state    <= ST_WAIT;
      cnt      <= '0;
      por_flag <= 1'b1;
      relock   <= 1'b0;
    end else begin
      case (state)
        ST_WAIT, ST_RUN: begin
          if (pin_low) begin
            state <= ST_LOW;
            cnt   <= ONE;
          end
        end
        ST_LOW: begin
          if (!pin_low) begin
            relock <= 1'b0;
            cnt    <= '0;
            if (qual || relock) state <= ST_HOLD;
            else if (por_flag)  state <= ST_WAIT;
            else                state <= ST_RUN;
          end else if (cnt < min_cur) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (pin_low) begin
            state  <= ST_LOW;
            cnt    <= ONE;
            relock <= 1'b1;
          end else if (cnt == HOLD_LAST) begin
            state    <= ST_RUN;
            cnt      <= '0;
            por_flag <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  always_comb begin
    accept = 1'b0;
    if (pin_low) begin
      if (state == ST_LOW) accept = (cnt == min_cur - 1'b1);
      else                 accept = (min_cur == ONE);
    end
  end

  assign rst_active = (state == ST_HOLD) || ((state == ST_LOW) && (qual || relock));
  assign in_reset   = (state == ST_WAIT) || rst_active || ((state == ST_LOW) && por_flag);
  assign is_por     = por_flag;
endmodule

// File: rtl/rstseq_outs.sv
module rstseq_outs #(
  parameter int unsigned MAP_W       = 8,
  parameter logic [MAP_W-1:0] MAP_DEFAULT = 8'hA5,
  parameter int unsigned CODE_BIT    = 0,
  parameter int unsigned PERIPH_BIT  = 7
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             in_reset,
  input  logic             rst_active,
  input  logic             is_por,
  input  logic             accept,
  input  logic             flash_busy,
  input  logic             wr_lockout,
  input  logic             pd_req,
  output logic             ready,
  output logic             clr_pm,
  output logic             clr_gen,
  output logic             clr_mcell,
  output logic             map_load,
  output logic [MAP_W-1:0] map_init,
  output logic             mcu_in_force,
  output logic             addr_tri,
  output logic             periph_tri,
  output logic             flash_abort,
  output logic             wr_inhibit
);
  localparam logic [MAP_W-1:0] FORCE_MASK =
    (MAP_W'(1) << CODE_BIT) | (MAP_W'(1) << PERIPH_BIT);
  localparam logic [MAP_W-1:0] MAP_RST = MAP_DEFAULT & ~FORCE_MASK;

  always_ff @(posedge clk) begin
    if (clr) begin
      ready        <= 1'b0;
      clr_pm       <= 1'b0;
      clr_gen      <= 1'b0;
      clr_mcell    <= 1'b0;
      map_load     <= 1'b0;
      mcu_in_force <= 1'b1;
      addr_tri     <= 1'b1;
      periph_tri   <= 1'b1;
      flash_abort  <= 1'b0;
      wr_inhibit   <= 1'b1;
    end else begin
      ready        <= ~in_reset;
      clr_gen      <= rst_active;
      map_load     <= rst_active;
      clr_pm       <= rst_active & is_por;
      clr_mcell    <= rst_active & is_por;
      mcu_in_force <= in_reset;
      addr_tri     <= in_reset | pd_req;
      periph_tri   <= in_reset | pd_req;
      flash_abort  <= accept & flash_busy;
      wr_inhibit   <= in_reset | wr_lockout;
    end
  end

  assign map_init = MAP_RST;
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
  parameter int unsigned POR_MIN_CYC  = 1000,
  parameter int unsigned WARM_MIN_CYC = 16,
  parameter int unsigned HOLD_CYC     = 256,
  parameter int unsigned MAP_W        = 8,
  parameter logic [MAP_W-1:0] MAP_DEFAULT = 8'hA5,
  parameter int unsigned CODE_BIT     = 0,
  parameter int unsigned PERIPH_BIT   = 7
) (
  input  logic             clk,
  input  logic             supply_ok,
  input  logic             rst_pin_n,
  input  logic             wr_lockout,
  input  logic             pd_req,
  input  logic             flash_busy,
  output logic             ready,
  output logic             clr_pm,
  output logic             clr_gen,
  output logic             clr_mcell,
  output logic             map_load,
  output logic [MAP_W-1:0] map_init,
  output logic             mcu_in_force,
  output logic             addr_tri,
  output logic             periph_tri,
  output logic             flash_abort,
  output logic             wr_inhibit
);
  logic clr_s;
  logic pin_lvl;
  logic in_reset, rst_active, is_por, accept;

  assign clr_s = ~supply_ok;

  rstseq_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .clr     (clr_s),
    .d_async (rst_pin_n),
    .q       (pin_lvl)
  );

  rstseq_ctrl #(
    .POR_MIN_CYC  (POR_MIN_CYC),
    .WARM_MIN_CYC (WARM_MIN_CYC),
    .HOLD_CYC     (HOLD_CYC)
  ) u_ctrl (
    .clk        (clk),
    .clr        (clr_s),
    .pin_lvl    (pin_lvl),
    .in_reset   (in_reset),
    .rst_active (rst_active),
    .is_por     (is_por),
    .accept     (accept)
  );

  rstseq_outs #(
    .MAP_W       (MAP_W),
    .MAP_DEFAULT (MAP_DEFAULT),
    .CODE_BIT    (CODE_BIT),
    .PERIPH_BIT  (PERIPH_BIT)
  ) u_outs (
    .clk          (clk),
    .clr          (clr_s),
    .in_reset     (in_reset),
    .rst_active   (rst_active),
    .is_por       (is_por),
    .accept       (accept),
    .flash_busy   (flash_busy),
    .wr_lockout   (wr_lockout),
    .pd_req       (pd_req),
    .ready        (ready),
    .clr_pm       (clr_pm),
    .clr_gen      (clr_gen),
    .clr_mcell    (clr_mcell),
    .map_load     (map_load),
    .map_init     (map_init),
    .mcu_in_force (mcu_in_force),
    .addr_tri     (addr_tri),
    .periph_tri   (periph_tri),
    .flash_abort  (flash_abort),
    .wr_inhibit   (wr_inhibit)
  );
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
  input logic clk,
  input logic supply_ok,
  input logic wr_lockout,
  input logic pd_req,
  input logic flash_busy,
  input logic ready,
  input logic clr_pm,
  input logic clr_gen,
  input logic clr_mcell,
  input logic map_load,
  input logic mcu_in_force,
  input logic periph_tri,
  input logic flash_abort,
  input logic wr_inhibit
);
  // R9
  abort_single_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    flash_abort |=> !flash_abort);
  // R9
  abort_busy_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    flash_abort |-> $past(flash_busy));
  // R5
  pm_in_window_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    clr_pm |-> clr_gen);
  // R5
  mcell_in_window_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    clr_mcell |-> clr_gen);
  // R6
  map_load_window_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    $rose(map_load) |-> clr_gen);
  // R7
  ready_port_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    ready |-> !mcu_in_force);
  // R4
  ready_after_clear_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    $rose(ready) |-> !clr_gen);
  // R8
  pd_float_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    pd_req |=> periph_tri);
  // R10
  lockout_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    $past(wr_lockout) |-> wr_inhibit);
endmodule

bind reset_sequencer rstseq_chk u_chk (.*);

// File: tb/tb_reset_sequencer.sv
module tb_reset_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int POR_MIN  = 16;
  localparam int WARM_MIN = 4;
  localparam int HOLD     = 8;
  localparam logic [7:0] MAP_DEF = 8'hFF;
  localparam logic [7:0] MAP_EXP = 8'h7E;  // bits 0 and 7 forced to zero

  // {pulse length, flash_busy, pd_req}
  localparam int NVEC = 7;
  localparam logic [7:0] WARM_VEC [0:NVEC-1] = '{
    {6'd3,  1'b1, 1'b0},
    {6'd4,  1'b1, 1'b0},
    {6'd4,  1'b0, 1'b0},
    {6'd9,  1'b1, 1'b1},
    {6'd1,  1'b0, 1'b1},
    {6'd12, 1'b0, 1'b0},
    {6'd5,  1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic supply_ok = 1'b0, rst_pin_n = 1'b1, wr_lockout = 1'b0, pd_req = 1'b0, flash_busy = 1'b0;
  logic ready, clr_pm, clr_gen, clr_mcell, map_load, mcu_in_force, addr_tri, periph_tri;
  logic flash_abort, wr_inhibit;
  logic [7:0] map_init;

  int n_chk = 0, n_fail = 0;
  int c_clr, c_pm, c_mc, c_rdy0, c_ab, c_mcu, c_load, rise_at, map_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_sequencer #(
    .POR_MIN_CYC(POR_MIN), .WARM_MIN_CYC(WARM_MIN), .HOLD_CYC(HOLD),
    .MAP_W(8), .MAP_DEFAULT(MAP_DEF), .CODE_BIT(0), .PERIPH_BIT(7)
  ) dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive a low pulse of len sampled edges and watch outputs for total cycles.
  task automatic watch_pulse(input int len, input int total);
    logic prev_rdy;
    c_clr = 0; c_pm = 0; c_mc = 0; c_rdy0 = 0; c_ab = 0; c_mcu = 0; c_load = 0;
    rise_at = -1; map_bad = 0;
    prev_rdy = ready;
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      c_clr  += int'(clr_gen);
      c_pm   += int'(clr_pm);
      c_mc   += int'(clr_mcell);
      c_rdy0 += int'(!ready);
      c_ab   += int'(flash_abort);
      c_mcu  += int'(mcu_in_force);
      c_load += int'(map_load);
      if (map_load && map_init != MAP_EXP) map_bad++;
      if (ready && !prev_rdy && rise_at < 0) rise_at = i;
      prev_rdy = ready;
      rst_pin_n = (i < len) ? 1'b0 : 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail + 1);
    $finish;
  end

  initial begin
    int win;
    // R1: reset state while supply is not good
    repeat (3) @(negedge clk);
    check(ready == 0 && mcu_in_force && addr_tri && periph_tri && wr_inhibit, "R1", ready, 0);
    check(!clr_gen && !clr_pm && !clr_mcell && !map_load && !flash_abort, "R1 clears", clr_gen, 0);

    supply_ok = 1'b1;
    repeat (4) @(negedge clk);
    check(ready == 0, "R1 waiting", ready, 0);

    // R2: power-on pulse one short of the minimum is not accepted
    watch_pulse(POR_MIN - 1, 40);
    check(c_clr == 0 && c_pm == 0, "R2 short", c_clr, 0);
    check(ready == 0, "R2 short ready", ready, 0);

    // R2/R5/R6/R9: exact power-on pulse with flash busy
    flash_busy = 1'b1;
    watch_pulse(POR_MIN, POR_MIN + HOLD + 12);
    flash_busy = 1'b0;
    check(c_clr == 1 + HOLD, "R5 gen por", c_clr, 1 + HOLD);
    check(c_pm == 1 + HOLD && c_mc == 1 + HOLD, "R5 pm por", c_pm, 1 + HOLD);
    check(c_load == 1 + HOLD && map_bad == 0, "R6", c_load, 1 + HOLD);
    check(c_ab == 1, "R9 por abort", c_ab, 1);
    check(rise_at == POR_MIN + HOLD + 4, "R4 por", rise_at, POR_MIN + HOLD + 4);
    check(ready == 1 && !mcu_in_force && !addr_tri && !periph_tri, "R7 run", ready, 1);
    check(wr_inhibit == 0, "R10 run", wr_inhibit, 0);

    // R3/R4/R5/R7/R8/R9: warm reset table
    for (int v = 0; v < NVEC; v++) begin
      int len; bit busy, pd, acc;
      len  = int'(WARM_VEC[v][7:2]);
      busy = WARM_VEC[v][1];
      pd   = WARM_VEC[v][0];
      acc  = (len >= WARM_MIN);
      win  = len + HOLD + 12;
      flash_busy = busy; pd_req = pd;
      watch_pulse(len, win);
      check(c_clr == (acc ? len - WARM_MIN + 1 + HOLD : 0), "R5 gen warm", c_clr,
            acc ? len - WARM_MIN + 1 + HOLD : 0);
      check(c_pm == 0 && c_mc == 0, "R5 warm keeps pm", c_pm, 0);
      check(c_rdy0 == c_clr && c_mcu == c_clr, "R3/R7 window", c_rdy0, c_clr);
      check(c_ab == ((acc && busy) ? 1 : 0), "R9 warm abort", c_ab, (acc && busy) ? 1 : 0);
      if (acc) check(rise_at == len + HOLD + 4, "R4 warm", rise_at, len + HOLD + 4);
      check(ready == 1 && periph_tri == pd && addr_tri == pd && !mcu_in_force, "R8 ports",
            periph_tri, pd);
      flash_busy = 1'b0; pd_req = 1'b0;
      @(negedge clk);
    end

    // R8: power-down alone
    pd_req = 1'b1;
    @(negedge clk);
    check(periph_tri && addr_tri && !mcu_in_force && ready && !clr_gen, "R8", periph_tri, 1);
    pd_req = 1'b0;
    @(negedge clk);
    check(!periph_tri, "R8 release", periph_tri, 0);

    // R10: write lockout
    wr_lockout = 1'b1;
    @(negedge clk);
    check(wr_inhibit == 1, "R10 lockout", wr_inhibit, 1);
    wr_lockout = 1'b0;
    @(negedge clk);
    check(wr_inhibit == 0, "R10 release", wr_inhibit, 0);

    // R1/R2: supply drop re-arms power-on; a warm-length pulse is then not enough
    supply_ok = 1'b0;
    @(negedge clk);
    check(ready == 0 && wr_inhibit && mcu_in_force, "R1 drop", ready, 0);
    supply_ok = 1'b1;
    repeat (3) @(negedge clk);
    flash_busy = 1'b1;
    watch_pulse(WARM_MIN * 2, 40);
    check(c_clr == 0 && ready == 0 && c_ab == 0, "R2 rearm", c_clr, 0);
    watch_pulse(POR_MIN + 2, POR_MIN + HOLD + 14);
    flash_busy = 1'b0;
    check(c_pm == 3 + HOLD && c_ab == 1, "R5 por again", c_pm, 3 + HOLD);
    check(ready == 1, "R4 por again", ready, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule